// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block sits beside an 8-bit microcontroller core. It decides when the core is held in reset and when its clocks run. The external reset pin is asynchronous and active high. The block synchronises it and measures how long it stays high, counting in machine cycles of twelve oscillator clocks. Only a pulse that lasts two whole machine cycles becomes an internal reset. When that happens, the block emits a single-cycle set of load strobes for the register file:

- the stack pointer is loaded with 07h;
- the port latches are set high;
- every other special function register is cleared, except the serial data buffer, whose strobe is never raised.

The block also holds the two power-mode bits of the power control register. A write to that register can put the core into one of two low-power modes:

- **Idle** gates the core clock but keeps the oscillator running. An interrupt or a reset ends it.
- **Power-down** stops the oscillator as well. Only a reset ends it. The oscillator enable comes back as soon as the synchronised reset pin is seen high, so that the qualification count can proceed.

Top module: `cpu_pwr_rst_ctrl`

## Requirements
- R1: The reset pin passes through a two-stage synchroniser. The internal reset `core_rst` rises when the synchronised pin has been high for 24 consecutive clocks (two machine cycles of 12 clocks). Counting from the clock edge after the pin rises, that is just after the 26th rising edge.
- R2: A pin pulse shorter than 24 clocks produces no internal reset. The count restarts from zero whenever the synchronised pin is low for a single clock, so two short pulses never add up.
- R3: `core_rst` stays high for as long as the pin stays high. It falls after the second rising edge following the pin's fall.
- R4: In the first cycle of `core_rst`, and only then, `sp_load`, `port_set` and every bit of `sfr_clr` pulse high. The exceptions are bit 1 (stack pointer) and bit 9 (serial buffer) of `sfr_clr`, which stay low. `sp_init` reads 07h.
- R5: A power register write (`pwr_wr`) with `wr_idle`=1 and `wr_pd`=0 enters idle. From the next cycle `core_clk_en`=0, `osc_en`=1 and `pcon_idle`=1.
- R6: In idle, an `irq_pend` sampled at a rising edge sets `core_clk_en` from that edge on. `pcon_idle` clears one clock later.
- R7: A write with `wr_pd`=1 enters power-down. From the next cycle `osc_en`=0 and `core_clk_en`=0. `irq_pend` has no effect in this mode.
- R8: Power-down ends only through R1. `osc_en` returns two edges after the pin rises. When reset is recognised `core_clk_en` returns, and one edge later `pcon_pd` and `pcon_idle` read 0.
- R9: A write with both `wr_idle` and `wr_pd` set stores both bits, and the block enters power-down rather than idle.
- R10: Power register writes are ignored while the core clock is stopped and while `core_rst` is high.
- R11: Idle also ends on a recognised reset. `core_clk_en` returns together with `core_rst`, and `pcon_idle` reads 0 one edge later.
- R12: While `por_n` is low, the block is in its reset state: `core_clk_en`=1, `osc_en`=1, `core_rst`=0, both mode bits 0 and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset of the controller itself, async assert, active low |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| pwr_wr | input | 1 | Write strobe for the power control register |
| wr_idle | input | 1 | Idle bit value carried by the write |
| wr_pd | input | 1 | Power-down bit value carried by the write |
| irq_pend | input | 1 | An enabled interrupt is pending |
| core_clk_en | output | 1 | Clock enable for the core |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Qualified internal reset |
| sp_load | output | 1 | Load strobe for the stack pointer |
| sp_init | output | 8 | Value loaded into the stack pointer (07h) |
| port_set | output | 1 | Strobe that sets all port latches high |
| sfr_clr | output | NUM_SFR | Per-register clear strobes |
| pcon_idle | output | 1 | Current idle bit |
| pcon_pd | output | 1 | Current power-down bit |

## Verification
The reset path is tried with several pin patterns, each separating a different fault:

- A long pulse pins the exact recognition edge.
- A 23-clock pulse separates a correct threshold from an off-by-one.
- Two short pulses split by a single low clock separate a restarting count from an accumulating one.

The mode logic is tried with:

- idle left through an interrupt;
- idle left through a reset;
- power-down with interrupts and writes applied, to show both are ignored;
- a combined idle-plus-power-down write, which shows which mode takes precedence;
- an asynchronous power-on reset in mid-idle.

A behavioural reference model tracks every output on every clock.

// File: rtl/rpc_pkg.sv
`timescale 1ns/1ps
package rpc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PDN  = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/rpc_sync.sv
`timescale 1ns/1ps
module rpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rpc_rst_qual.sv
`timescale 1ns/1ps
module rpc_rst_qual #(
  parameter int CLKS_PER_MC = 12,
  parameter int MIN_MC      = 2,
  parameter int NUM_SFR     = 16,
  parameter int SP_IDX      = 1,
  parameter int SBUF_IDX    = 9
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               pin_s,
  output logic               core_rst,
  output logic               sp_load,
  output logic               port_set,
  output logic [NUM_SFR-1:0] sfr_clr
);
  localparam int PW = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
  localparam int MW = $clog2(MIN_MC + 1);

  logic [PW-1:0] ph_q, ph_d;
  logic [MW-1:0] mc_q, mc_d;
  logic          rst_q;
  logic          qual_done;
  logic          init_p;

  assign qual_done = (mc_q == MW'(MIN_MC));

  // phase within a machine cycle and completed machine cycles, pin high only
  always_comb begin
    ph_d = ph_q;
    mc_d = mc_q;
    if (!pin_s) begin
      ph_d = '0;
      mc_d = '0;
    end else if (!qual_done) begin
      if (ph_q == PW'(CLKS_PER_MC - 1)) begin
        ph_d = '0;
        mc_d = mc_q + MW'(1);
      end else begin
        ph_d = ph_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_q  <= '0;
      mc_q  <= '0;
      rst_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      mc_q  <= mc_d;
      rst_q <= core_rst;
    end
  end

  assign core_rst = pin_s & qual_done;
  assign init_p   = core_rst & ~rst_q;
  assign sp_load  = init_p;
  assign port_set = init_p;

  for (genvar g = 0; g < NUM_SFR; g++) begin : g_clr
    if (g == SP_IDX || g == SBUF_IDX) begin : g_keep
      assign sfr_clr[g] = 1'b0;
    end else begin : g_zero
      assign sfr_clr[g] = init_p;
    end
  end

  // R1
  rst_needs_pin_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst) |-> $past(pin_s));
  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !pin_s |=> !core_rst);
  // R4
  load_once_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sp_load |=> !sp_load);
endmodule

// File: rtl/rpc_mode_fsm.sv
`timescale 1ns/1ps
module rpc_mode_fsm
  import rpc_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic core_rst,
  input  logic pin_s,
  input  logic pwr_wr,
  input  logic wr_idle,
  input  logic wr_pd,
  input  logic irq_pend,
  output logic core_clk_en,
  output logic osc_en,
  output logic pcon_idle,
  output logic pcon_pd
);
  pwr_mode_e st_q, st_d;
  logic      idle_q, idle_d;
  logic      pd_q, pd_d;
  logic      wake_q, wake_d;

  always_comb begin
    st_d   = st_q;
    idle_d = idle_q;
    pd_d   = pd_q;
    wake_d = 1'b0;
    if (core_rst) begin
      st_d   = MODE_RUN;
      idle_d = 1'b0;
      pd_d   = 1'b0;
    end else begin
      if (wake_q) idle_d = 1'b0;
      unique case (st_q)
        MODE_RUN: begin
          if (pwr_wr) begin
            idle_d = wr_idle;
            pd_d   = wr_pd;
            if (wr_pd)        st_d = MODE_PDN;
            else if (wr_idle) st_d = MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (irq_pend) begin
            st_d   = MODE_RUN;
            wake_d = 1'b1;
          end
        end
        MODE_PDN: begin
          st_d = MODE_PDN;
        end
        default: st_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= MODE_RUN;
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idle_q <= idle_d;
      pd_q   <= pd_d;
      wake_q <= wake_d;
    end
  end

  assign core_clk_en = (st_q == MODE_RUN) | core_rst;
  assign osc_en      = (st_q != MODE_PDN) | pin_s;
  assign pcon_idle   = idle_q;
  assign pcon_pd     = pd_q;

  // R8
  pd_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == MODE_PDN && !core_rst) |=> (st_q == MODE_PDN));
  // R6
  idle_wake_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == MODE_IDLE && irq_pend && !core_rst) |=> core_clk_en);
  // R10
  no_wr_stopped_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_clk_en && !core_rst) |=> $stable(pcon_pd));
endmodule

// File: rtl/cpu_pwr_rst_ctrl.sv
`timescale 1ns/1ps
module cpu_pwr_rst_ctrl #(
  parameter int         CLKS_PER_MC = 12,
  parameter int         MIN_MC      = 2,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_SFR     = 16,
  parameter int         SP_IDX      = 1,
  parameter int         SBUF_IDX    = 9,
  parameter logic [7:0] SP_RESET    = 8'h07
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_pin,
  input  logic               pwr_wr,
  input  logic               wr_idle,
  input  logic               wr_pd,
  input  logic               irq_pend,
  output logic               core_clk_en,
  output logic               osc_en,
  output logic               core_rst,
  output logic               sp_load,
  output logic [7:0]         sp_init,
  output logic               port_set,
  output logic [NUM_SFR-1:0] sfr_clr,
  output logic               pcon_idle,
  output logic               pcon_pd
);
  logic pin_s;

  rpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      (rst_pin),
    .q      (pin_s)
  );

  rpc_rst_qual #(
    .CLKS_PER_MC (CLKS_PER_MC),
    .MIN_MC      (MIN_MC),
    .NUM_SFR     (NUM_SFR),
    .SP_IDX      (SP_IDX),
    .SBUF_IDX    (SBUF_IDX)
  ) u_qual (
    .clk      (clk),
    .arst_n   (por_n),
    .pin_s    (pin_s),
    .core_rst (core_rst),
    .sp_load  (sp_load),
    .port_set (port_set),
    .sfr_clr  (sfr_clr)
  );

  rpc_mode_fsm u_fsm (
    .clk         (clk),
    .arst_n      (por_n),
    .core_rst    (core_rst),
    .pin_s       (pin_s),
    .pwr_wr      (pwr_wr),
    .wr_idle     (wr_idle),
    .wr_pd       (wr_pd),
    .irq_pend    (irq_pend),
    .core_clk_en (core_clk_en),
    .osc_en      (osc_en),
    .pcon_idle   (pcon_idle),
    .pcon_pd     (pcon_pd)
  );

  assign sp_init = SP_RESET;

  // R7
  osc_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    !osc_en |-> pcon_pd);
  // R5
  gated_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    !core_clk_en |-> (pcon_idle | pcon_pd));
endmodule

// File: tb/cpu_pwr_rst_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_pwr_rst_ctrl_bench;
  localparam int NSFR = 16;
  localparam int QUAL = 24;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b0, pwr_wr = 1'b0, wr_idle = 1'b0, wr_pd = 1'b0, irq_pend = 1'b0;
  logic core_clk_en, osc_en, core_rst, sp_load, port_set, pcon_idle, pcon_pd;
  logic [7:0] sp_init;
  logic [NSFR-1:0] sfr_clr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  cpu_pwr_rst_ctrl u_cpu_pwr_rst_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .pwr_wr(pwr_wr),
    .wr_idle(wr_idle), .wr_pd(wr_pd), .irq_pend(irq_pend),
    .core_clk_en(core_clk_en), .osc_en(osc_en), .core_rst(core_rst),
    .sp_load(sp_load), .sp_init(sp_init), .port_set(port_set),
    .sfr_clr(sfr_clr), .pcon_idle(pcon_idle), .pcon_pd(pcon_pd)
  );

  function automatic logic [NSFR-1:0] clr_mask();
    logic [NSFR-1:0] m = '0;
    for (int i = 0; i < NSFR; i++) m[i] = !(i == 1 || i == 9);
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, compared every clock
  int m_s1, m_s2, m_run, m_prev, m_mode, m_idle, m_pd, m_wake;
  always @(posedge clk) begin
    if (!por_n) begin
      m_s1 = 0; m_s2 = 0; m_run = 0; m_prev = 0;
      m_mode = 0; m_idle = 0; m_pd = 0; m_wake = 0;
    end else begin
      int cur;
      cur = (m_s2 != 0 && m_run >= QUAL) ? 1 : 0;
      m_prev = cur;
      if (cur != 0) begin
        m_mode = 0; m_idle = 0; m_pd = 0; m_wake = 0;
      end else begin
        if (m_wake != 0) m_idle = 0;
        m_wake = 0;
        if (m_mode == 0 && pwr_wr) begin
          m_idle = wr_idle; m_pd = wr_pd;
          m_mode = wr_pd ? 2 : (wr_idle ? 1 : 0);
        end else if (m_mode == 1 && irq_pend) begin
          m_mode = 0; m_wake = 1;
        end
      end
      m_run = (m_s2 != 0) ? ((m_run < QUAL) ? m_run + 1 : QUAL) : 0;
      m_s2 = m_s1; m_s1 = rst_pin;
    end
    #1;
    begin
      int e_rst, e_stb;
      e_rst = (m_s2 != 0 && m_run >= QUAL) ? 1 : 0;
      e_stb = (e_rst != 0 && m_prev == 0) ? 1 : 0;
      chk("R1 model core_rst", core_rst, e_rst);
      chk("R4 model sp_load", sp_load, e_stb);
      chk("R4 model port_set", port_set, e_stb);
      chk("R4 model sfr_clr", sfr_clr, (e_stb != 0) ? clr_mask() : '0);
      chk("R5 model core_clk_en", core_clk_en, (m_mode == 0 || e_rst != 0) ? 1 : 0);
      chk("R7 model osc_en", osc_en, (m_mode != 2 || m_s2 != 0) ? 1 : 0);
      chk("R6 model pcon_idle", pcon_idle, m_idle);
      chk("R8 model pcon_pd", pcon_pd, m_pd);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pcon(input logic i, input logic p);
    pwr_wr = 1'b1; wr_idle = i; wr_pd = p;
    cyc(1);
    pwr_wr = 1'b0; wr_idle = 1'b0; wr_pd = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R12 reset state
    chk("R12 clk_en", core_clk_en, 1); chk("R12 osc_en", osc_en, 1);
    chk("R12 core_rst", core_rst, 0); chk("R12 idle", pcon_idle, 0);
    por_n = 1'b1;
    cyc(2);

    // R1 / R4 / R3 long pulse
    rst_pin = 1'b1;
    cyc(25); chk("R1 not yet", core_rst, 0);
    cyc(1);  chk("R1 recognised", core_rst, 1);
    chk("R4 sfr_clr", sfr_clr, clr_mask()); chk("R4 sp_load", sp_load, 1);
    chk("R4 port_set", port_set, 1); chk("R4 sp_init", sp_init, 8'h07);
    // R10 write during reset ignored
    pwr_wr = 1'b1; wr_idle = 1'b1;
    cyc(1); chk("R4 single pulse", sp_load, 0);
    pwr_wr = 1'b0; wr_idle = 1'b0;
    cyc(1); chk("R10 write in reset", pcon_idle, 0);
    cyc(30); chk("R3 held", core_rst, 1);
    rst_pin = 1'b0;
    cyc(1); chk("R3 still high", core_rst, 1);
    cyc(1); chk("R3 released", core_rst, 0);
    cyc(3);

    // R2 short and broken pulses
    rst_pin = 1'b1; cyc(23); rst_pin = 1'b0;
    cyc(4); chk("R2 23-clock pulse", core_rst, 0);
    rst_pin = 1'b1; cyc(20); rst_pin = 1'b0; cyc(1);
    rst_pin = 1'b1; cyc(20); rst_pin = 1'b0;
    cyc(4); chk("R2 split pulses", core_rst, 0);

    // R5 / R6 idle via interrupt
    wr_pcon(1'b1, 1'b0);
    chk("R5 clk gated", core_clk_en, 0); chk("R5 osc on", osc_en, 1);
    chk("R5 idle bit", pcon_idle, 1);
    cyc(4);
    irq_pend = 1'b1; cyc(1); irq_pend = 1'b0;
    chk("R6 clk back", core_clk_en, 1); chk("R6 idle still set", pcon_idle, 1);
    cyc(1); chk("R6 idle cleared", pcon_idle, 0);
    cyc(2);

    // R7 / R10 / R8 power-down
    wr_pcon(1'b0, 1'b1);
    chk("R7 osc off", osc_en, 0); chk("R7 clk off", core_clk_en, 0);
    irq_pend = 1'b1; cyc(2); irq_pend = 1'b0;
    chk("R7 irq ignored", core_clk_en, 0);
    pwr_wr = 1'b1; cyc(1); pwr_wr = 1'b0;
    cyc(1); chk("R10 write while stopped", pcon_pd, 1);
    rst_pin = 1'b1;
    cyc(1); chk("R8 osc waits sync", osc_en, 0);
    cyc(1); chk("R8 osc restarts", osc_en, 1);
    cyc(24); chk("R8 reset exit", core_clk_en, 1);
    cyc(1); chk("R8 pd cleared", pcon_pd, 0);
    rst_pin = 1'b0; cyc(4);

    // R9 both bits
    wr_pcon(1'b1, 1'b1);
    chk("R9 osc off", osc_en, 0); chk("R9 pd bit", pcon_pd, 1); chk("R9 idle bit", pcon_idle, 1);
    irq_pend = 1'b1; cyc(1); irq_pend = 1'b0;
    chk("R9 irq ignored", core_clk_en, 0);
    rst_pin = 1'b1; cyc(30); rst_pin = 1'b0; cyc(4);
    chk("R9 left by reset", pcon_pd, 0);

    // R11 idle via reset
    wr_pcon(1'b1, 1'b0);
    rst_pin = 1'b1;
    cyc(25); chk("R11 still idle", core_clk_en, 0);
    cyc(1);  chk("R11 clk back", core_clk_en, 1);
    cyc(1);  chk("R11 idle cleared", pcon_idle, 0);
    rst_pin = 1'b0; cyc(4);

    // R12 power-on reset mid-idle
    wr_pcon(1'b1, 1'b0);
    cyc(2);
    por_n = 1'b0;
    cyc(1);
    chk("R12 por clk_en", core_clk_en, 1); chk("R12 por idle", pcon_idle, 0);
    chk("R12 por strobe", sp_load, 0);
    por_n = 1'b1;
    cyc(5);

    done = 1;
    summary();
    $finish;
  end
endmodule